// File: doc/BRIEF.md
# YUV to RGB Colour Converter

This block turns a stream of 8-bit luma/chroma pixel triples (Y, U, V) into 8-bit R, G, B. It does this with a programmable 3x4 matrix: each output channel is a weighted sum of Y, U and V plus a constant. Pixels enter and leave on valid/ready handshakes. The pipeline accepts one pixel per clock when the consumer is ready. A pass-through mode forwards pixels that are already RGB without changing them.

A host loads twelve coefficient words and a pass-through flag through a simple write port. These writes land in a shadow copy. The working copy takes the shadow contents only when a one-cycle frame-start pulse arrives, so a frame is never converted with a half-written matrix. Each pixel is converted with the settings that were working on the cycle it was accepted. After reset the working copy holds a standard-definition studio-range matrix, which maps Y in 16..235 and U/V in 16..240 to full-range 0..255 RGB.

Top module: `yuv_rgb_convert`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, pass-through is off, and both coefficient copies hold the default words. These are addresses 0..3 = 0x04A7, 0x1E6F, 0x1CBF, 0x0877; 4..7 = 0x04A7, 0x0000, 0x0662, 0x3211; 8..11 = 0x04A7, 0x0812, 0x0000, 0x2EB1.
- R2: Address 0..3 is the G row, 4..7 the R row and 8..11 the B row. Within a row, offsets +0, +1 and +2 weight Y, U and V, and offset +3 is the constant. Bit 0 at address 12 is the pass-through flag. Writes to addresses 13..15 change nothing.
- R3: Weight words are 13-bit two's complement with 10 fractional bits, so `cfg_wdata` bit 13 is ignored for them. Constants are 14-bit two's complement with 4 fractional bits.
- R4: Each channel equals floor((w0*Y + w1*U + w2*V + k*64 + 512) / 1024), where w and k are the signed integer values of the words.
- R5: Each channel result is clamped to the range 0..255.
- R6: When pass-through is working, `out_r`=`in_c0`, `out_g`=`in_c1` and `out_b`=`in_c2`.
- R7: A write reaches the working copy only at a `frame_start` pulse. A write made in the same cycle as the pulse waits for the next pulse.
- R8: A pixel is converted with the working settings of its acceptance cycle. A pulse while the pixel is in flight does not change its result.
- R9: With `out_ready` held at 1, a pixel accepted at clock edge k is on the output after edge k+2, and back-to-back pixels are accepted every cycle.
- R10: While `out_valid`=1 and `out_ready`=0, the outputs hold steady and no pixel is lost or reordered. `in_ready` is 1 whenever the output is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Word address (0..11 matrix, 12 pass-through) |
| cfg_wdata | input | 14 | Write data |
| frame_start | input | 1 | Frame boundary pulse; commits shadow settings |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_c0 | input | 8 | Y, or R in pass-through |
| in_c1 | input | 8 | U, or G in pass-through |
| in_c2 | input | 8 | V, or B in pass-through |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
The bench drives extreme inputs (all-zero and all-255) through the default matrix. A clamp that wrapped instead of saturating would show near-full values where 0 is expected. It writes a constant with its top bit set and a weight with bit 13 set, so an unsigned or mis-sized field would give large wrong outputs. It also issues a write in the very cycle of a frame pulse and a pulse while a pixel is in flight; a bank that committed too early, or a datapath that read coefficients after the first stage, would convert some pixels with the wrong matrix. Random back-pressure against a scoreboard exposes a stall that lets data slip or drops pixels.

// File: rtl/yuv_rgb_pkg.sv
// Shared constants and default coefficient words for the YUV to RGB converter.
package yuv_rgb_pkg;
    localparam int ROWS = 3;   // G, R, B in address order
    localparam int TAPS = 4;   // three weights plus one constant per row
    localparam int ROW_G = 0;
    localparam int ROW_R = 1;
    localparam int ROW_B = 2;

    // Default studio-range SD matrix word for linear index idx (row*TAPS+tap)
    function automatic logic [15:0] default_word(input int idx);
        case (idx)
            0:  return 16'h04a7;
            1:  return 16'h1e6f;
            2:  return 16'h1cbf;
            3:  return 16'h0877;
            4:  return 16'h04a7;
            5:  return 16'h0000;
            6:  return 16'h0662;
            7:  return 16'h3211;
            8:  return 16'h04a7;
            9:  return 16'h0812;
            10: return 16'h0000;
            11: return 16'h2eb1;
            default: return 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/csc_coef_bank.sv
// Coefficient bank: a host-written shadow copy and a working copy that loads
// from the shadow on a frame-start pulse.
// Assumes cfg_addr is wide enough to reach ROWS*TAPS (the pass-through word).
module csc_coef_bank
    import yuv_rgb_pkg::*;
#(
    parameter int MUL_W  = 13,
    parameter int OFS_W  = 14,
    parameter int CFG_AW = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [OFS_W-1:0]                  cfg_wdata,
    input  logic                              frame_start,
    output logic [ROWS*(TAPS-1)*MUL_W-1:0]    act_mul,
    output logic [ROWS*OFS_W-1:0]             act_ofs,
    output logic                              act_byp
);
    localparam int NMUL     = TAPS - 1;
    localparam int MUL_BITS = ROWS * NMUL * MUL_W;
    localparam int OFS_BITS = ROWS * OFS_W;
    localparam int BYP_ADDR = ROWS * TAPS;

    // Build the reset image of all weights
    function automatic logic [MUL_BITS-1:0] dflt_mul();
        logic [MUL_BITS-1:0] v;
        v = '0;
        for (int r = 0; r < ROWS; r++)
            for (int t = 0; t < NMUL; t++)
                v[(r*NMUL+t)*MUL_W +: MUL_W] = MUL_W'(default_word(r*TAPS+t));
        return v;
    endfunction

    // Build the reset image of all constants
    function automatic logic [OFS_BITS-1:0] dflt_ofs();
        logic [OFS_BITS-1:0] v;
        v = '0;
        for (int r = 0; r < ROWS; r++)
            v[r*OFS_W +: OFS_W] = OFS_W'(default_word(r*TAPS+NMUL));
        return v;
    endfunction

    localparam logic [MUL_BITS-1:0] DFLT_MUL = dflt_mul();
    localparam logic [OFS_BITS-1:0] DFLT_OFS = dflt_ofs();

    logic [MUL_BITS-1:0] sh_mul;
    logic [OFS_BITS-1:0] sh_ofs;
    logic                sh_byp;

    // Shadow copy: decode host writes; unmapped addresses fall through
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_mul <= DFLT_MUL;
            sh_ofs <= DFLT_OFS;
            sh_byp <= 1'b0;
        end else if (cfg_we) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int t = 0; t < NMUL; t++)
                    if (cfg_addr == CFG_AW'(r*TAPS+t))
                        sh_mul[(r*NMUL+t)*MUL_W +: MUL_W] <= cfg_wdata[MUL_W-1:0];
                if (cfg_addr == CFG_AW'(r*TAPS+NMUL))
                    sh_ofs[r*OFS_W +: OFS_W] <= cfg_wdata;
            end
            if (cfg_addr == CFG_AW'(BYP_ADDR))
                sh_byp <= cfg_wdata[0];
        end
    end

    // Working copy: load from shadow only at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mul <= DFLT_MUL;
            act_ofs <= DFLT_OFS;
            act_byp <= 1'b0;
        end else if (frame_start) begin
            act_mul <= sh_mul;
            act_ofs <= sh_ofs;
            act_byp <= sh_byp;
        end
    end
endmodule

// File: rtl/csc_row.sv
// One output channel: three-stage multiply / sum / round-and-clamp pipeline.
// Stage 1 captures products and the scaled constant, so coefficients are only
// read at acceptance. All stages advance together on adv.
module csc_row #(
    parameter int PIX_W     = 8,
    parameter int MUL_W     = 13,
    parameter int OFS_W     = 14,
    parameter int FRAC_W    = 10,
    parameter int OFS_SHIFT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic [3*MUL_W-1:0]   mul,
    input  logic [OFS_W-1:0]     ofs,
    input  logic                 byp,
    input  logic [PIX_W-1:0]     y,
    input  logic [PIX_W-1:0]     u,
    input  logic [PIX_W-1:0]     v,
    input  logic [PIX_W-1:0]     pass_pix,
    output logic [PIX_W-1:0]     pix
);
    localparam int PROD_W = MUL_W + PIX_W + 1;
    localparam int SUM_W  = PROD_W + 2;
    localparam logic signed [SUM_W-1:0] RND  = SUM_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [SUM_W-1:0] PMAX = SUM_W'((1 << PIX_W) - 1);

    logic signed [PROD_W-1:0] p0, p1, p2;
    logic signed [SUM_W-1:0]  k1, sum2;
    logic                     byp1, byp2;
    logic [PIX_W-1:0]         pass1, pass2;
    logic signed [SUM_W-1:0]  ofs_ext, e0, e1, e2, scaled;

    assign ofs_ext = {{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    assign e0 = {{(SUM_W-PROD_W){p0[PROD_W-1]}}, p0};
    assign e1 = {{(SUM_W-PROD_W){p1[PROD_W-1]}}, p1};
    assign e2 = {{(SUM_W-PROD_W){p2[PROD_W-1]}}, p2};
    assign scaled = sum2 >>> FRAC_W;

    // Stage 1: three signed products and the aligned, rounded constant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p0 <= '0; p1 <= '0; p2 <= '0; k1 <= '0;
            byp1 <= 1'b0; pass1 <= '0;
        end else if (adv) begin
            p0 <= $signed(mul[0*MUL_W +: MUL_W]) * $signed({1'b0, y});
            p1 <= $signed(mul[1*MUL_W +: MUL_W]) * $signed({1'b0, u});
            p2 <= $signed(mul[2*MUL_W +: MUL_W]) * $signed({1'b0, v});
            k1 <= (ofs_ext <<< OFS_SHIFT) + RND;
            byp1 <= byp;
            pass1 <= pass_pix;
        end
    end

    // Stage 2: accumulate the row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum2 <= '0; byp2 <= 1'b0; pass2 <= '0;
        end else if (adv) begin
            sum2 <= e0 + e1 + e2 + k1;
            byp2 <= byp1;
            pass2 <= pass1;
        end
    end

    // Stage 3: drop fraction, clamp to pixel range, or forward pass-through
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix <= '0;
        end else if (adv) begin
            if (byp2)
                pix <= pass2;
            else if (scaled < 0)
                pix <= '0;
            else if (scaled > PMAX)
                pix <= '1;
            else
                pix <= scaled[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/yuv_rgb_convert.sv
// YUV to RGB converter top: coefficient bank, three channel pipelines and the
// valid/ready control. Assumes frame_start is a single-cycle pulse.
// Latency is three cycles; a stalled output freezes every stage.
module yuv_rgb_convert
    import yuv_rgb_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int MUL_W      = 13,
    parameter int OFS_W      = 14,
    parameter int FRAC_W     = 10,
    parameter int OFS_FRAC_W = 4,
    parameter int CFG_AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [OFS_W-1:0]  cfg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_c0,
    input  logic [PIX_W-1:0]  in_c1,
    input  logic [PIX_W-1:0]  in_c2,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);
    localparam int NMUL      = TAPS - 1;
    localparam int OFS_SHIFT = FRAC_W - OFS_FRAC_W;

    logic [ROWS*NMUL*MUL_W-1:0] act_mul;
    logic [ROWS*OFS_W-1:0]      act_ofs;
    logic                       act_byp;
    logic                       adv, v1, v2, v3;
    logic [PIX_W-1:0]           pass_sel [ROWS];
    logic [PIX_W-1:0]           row_pix  [ROWS];

    csc_coef_bank #(
        .MUL_W(MUL_W), .OFS_W(OFS_W), .CFG_AW(CFG_AW)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .act_mul(act_mul), .act_ofs(act_ofs), .act_byp(act_byp)
    );

    assign adv      = !v3 || out_ready;
    assign in_ready = adv;

    // Valid pipeline: shifts together with the data stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
        end else if (adv) begin
            v1 <= in_valid;
            v2 <= v1;
            v3 <= v2;
        end
    end

    // Pass-through source per row (rows are G, R, B)
    assign pass_sel[ROW_G] = in_c1;
    assign pass_sel[ROW_R] = in_c0;
    assign pass_sel[ROW_B] = in_c2;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        csc_row #(
            .PIX_W(PIX_W), .MUL_W(MUL_W), .OFS_W(OFS_W),
            .FRAC_W(FRAC_W), .OFS_SHIFT(OFS_SHIFT)
        ) u_row (
            .clk(clk), .rst_n(rst_n), .adv(adv),
            .mul(act_mul[g*NMUL*MUL_W +: NMUL*MUL_W]),
            .ofs(act_ofs[g*OFS_W +: OFS_W]),
            .byp(act_byp),
            .y(in_c0), .u(in_c1), .v(in_c2),
            .pass_pix(pass_sel[g]),
            .pix(row_pix[g])
        );
    end

    assign out_valid = v3;
    assign out_r     = row_pix[ROW_R];
    assign out_g     = row_pix[ROW_G];
    assign out_b     = row_pix[ROW_B];
endmodule

// File: rtl/yuv_rgb_convert_chk.sv
// Protocol and commit checks for yuv_rgb_convert, attached with bind below.
module yuv_rgb_convert_chk #(
    parameter int PIX_W = 8,
    parameter int CW_W  = 117,
    parameter int CO_W  = 42
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_r,
    input logic [PIX_W-1:0] out_g,
    input logic [PIX_W-1:0] out_b,
    input logic             frame_start,
    input logic [CW_W-1:0]  act_mul,
    input logic [CO_W-1:0]  act_ofs,
    input logic             act_byp
);
    // R1: leaving reset, the output is empty and input is open
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && in_ready));

    // R7: the working settings move only after a frame pulse
    assert_commit_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> $stable({act_mul, act_ofs, act_byp}));

    // R9: accepted pixel appears three edges later when never stalled
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && in_ready, 2) && $past(out_ready) && out_ready) |=> out_valid);

    // R10: stalled output holds its pixel
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

    // R10: an empty output never blocks the input
    assert_ready_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
endmodule

bind yuv_rgb_convert yuv_rgb_convert_chk #(
    .PIX_W(PIX_W),
    .CW_W(yuv_rgb_pkg::ROWS*(yuv_rgb_pkg::TAPS-1)*MUL_W),
    .CO_W(yuv_rgb_pkg::ROWS*OFS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .frame_start(frame_start), .act_mul(act_mul), .act_ofs(act_ofs),
    .act_byp(act_byp)
);

// File: tb/tb_yuv_rgb_convert.sv
`timescale 1ns/1ps
module tb_yuv_rgb_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [13:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_r, out_g, out_b;

    int errors = 0;
    int checks = 0;
    bit rnd_ready = 1'b0;
    bit finished = 1'b0;
    int stall_waits = 0;
    int sh_w [13];
    int act_w [13];
    logic [23:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    yuv_rgb_convert dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int sx(input int val, input int w);
        return (val >= (1 << (w-1))) ? val - (1 << w) : val;
    endfunction

    // Requirement model of one channel (R4, R5)
    function automatic logic [7:0] chan(input int row, input int y, input int u, input int v);
        int s;
        s = sx(act_w[row*4], 13)*y + sx(act_w[row*4+1], 13)*u
          + sx(act_w[row*4+2], 13)*v + sx(act_w[row*4+3], 14)*64 + 512;
        s = s >>> 10;
        if (s < 0) return 8'd0;
        if (s > 255) return 8'd255;
        return s[7:0];
    endfunction

    function automatic logic [23:0] model(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        if (act_w[12] != 0) return {a, b, c};
        return {chan(1, a, b, c), chan(0, a, b, c), chan(2, a, b, c)};
    endfunction

    task automatic model_reset();
        int d [12] = '{'h04a7, 'h1e6f, 'h1cbf, 'h0877, 'h04a7, 0, 'h0662, 'h3211,
                       'h04a7, 'h0812, 0, 'h2eb1};
        for (int i = 0; i < 12; i++) begin sh_w[i] = d[i]; act_w[i] = d[i]; end
        sh_w[12] = 0; act_w[12] = 0;
    endtask

    // One control cycle: optional write and optional frame pulse, no pixel
    task automatic ctl_cycle(input bit we, input int addr, input int data, input bit start);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we = we; cfg_addr = 4'(addr); cfg_wdata = 14'(data); frame_start = start;
        if (start) for (int i = 0; i < 13; i++) act_w[i] = sh_w[i];
        if (we) begin
            if (addr < 12) sh_w[addr] = data & (((addr % 4) == 3) ? 'h3fff : 'h1fff);
            else if (addr == 12) sh_w[12] = data & 1;
        end
    endtask

    task automatic idle();
        ctl_cycle(1'b0, 0, 0, 1'b0);
    endtask

    task automatic write_word(input int addr, input int data);
        ctl_cycle(1'b1, addr, data, 1'b0);
    endtask

    task automatic pulse();
        ctl_cycle(1'b0, 0, 0, 1'b1);
    endtask

    // Driver: present a pixel, wait for acceptance, push expected result
    task automatic send(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input string req);
        @(negedge clk);
        cfg_we = 1'b0; frame_start = 1'b0;
        in_valid = 1'b1; in_c0 = a; in_c1 = b; in_c2 = c;
        #1;
        while (!in_ready) begin
            stall_waits++;
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(a, b, c));
        tag_q.push_back(req);
        @(posedge clk);
    endtask

    task automatic drain();
        idle();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    always @(negedge clk) out_ready <= rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1;

    // Monitor: stall hold checks and scoreboard compare
    initial begin
        bit hold_pending = 1'b0;
        logic [23:0] held = '0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (hold_pending)
                    check(out_valid && ({out_r, out_g, out_b} == held), "R10", "stalled output moved",
                          {7'd0, out_valid, out_r, out_g, out_b}, {8'h01, held});
                hold_pending = out_valid && !out_ready;
                held = {out_r, out_g, out_b};
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10", "unexpected pixel", {8'd0, out_r, out_g, out_b}, 32'd0);
                    end else begin
                        logic [23:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({out_r, out_g, out_b} == e, t, "pixel rgb",
                              {8'd0, out_r, out_g, out_b}, {8'd0, e});
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);

        // R1/R4: default matrix on typical pixels
        send(8'd16, 8'd128, 8'd128, "R1");
        send(8'd235, 8'd128, 8'd128, "R1");
        send(8'd81, 8'd90, 8'd240, "R4");
        send(8'd145, 8'd54, 8'd34, "R4");
        send(8'd41, 8'd240, 8'd110, "R4");
        // R5: clamp at both ends
        send(8'd255, 8'd255, 8'd255, "R5");
        send(8'd0, 8'd0, 8'd0, "R5");
        send(8'd235, 8'd16, 8'd240, "R5");
        drain();

        // R9: latency of a lone pixel
        begin
            int k;
            send(8'd100, 8'd100, 8'd100, "R9");
            k = 0;
            do begin
                @(negedge clk);
                in_valid = 1'b0;
                #2;
                k++;
            end while (!out_valid && k < 10);
            check(k == 3, "R9", "latency in cycles", 32'(k), 32'd3);
        end
        drain();

        // R9: back-to-back acceptance without waits
        stall_waits = 0;
        for (int i = 0; i < 8; i++) send(8'(20 + i*25), 8'(200 - i*20), 8'(30 + i*10), "R9");
        check(stall_waits == 0, "R9", "input waits at full rate", 32'(stall_waits), 32'd0);
        drain();

        // R7: writes without a pulse leave the working matrix alone
        write_word(0, 0); write_word(1, 'h400); write_word(2, 0); write_word(3, 0);
        write_word(4, 'h400); write_word(5, 0); write_word(6, 0); write_word(7, 'h100);
        write_word(8, 0); write_word(9, 0); write_word(10, 'h400); write_word(11, 'h3f00);
        send(8'd50, 8'd60, 8'd70, "R7");
        // R2: after the pulse, row order G,R,B and tap order Y,U,V,constant
        pulse();
        send(8'd50, 8'd60, 8'd70, "R2");
        send(8'd250, 8'd5, 8'd10, "R2");
        send(8'd3, 8'd200, 8'd255, "R3");
        drain();

        // R8: reload defaults in shadow; pulse while a pixel is in flight
        write_word(0, 'h04a7); write_word(1, 'h1e6f); write_word(2, 'h1cbf); write_word(3, 'h0877);
        write_word(4, 'h04a7); write_word(5, 0); write_word(6, 'h0662); write_word(7, 'h3211);
        write_word(8, 'h04a7); write_word(9, 'h0812); write_word(10, 0); write_word(11, 'h2eb1);
        send(8'd120, 8'd80, 8'd90, "R8");
        pulse();
        send(8'd120, 8'd80, 8'd90, "R8");
        drain();

        // R7: write in the same cycle as the pulse waits for the next pulse
        ctl_cycle(1'b1, 0, 0, 1'b1);
        send(8'd180, 8'd100, 8'd60, "R7");
        pulse();
        send(8'd180, 8'd100, 8'd60, "R7");
        write_word(0, 'h04a7);
        pulse();
        drain();

        // R2/R3: unmapped addresses and weight bit 13 are ignored
        write_word(13, 'h3fff); write_word(14, 'h3fff); write_word(15, 'h3fff);
        write_word(4, 'h2000 | 'h04a7);
        pulse();
        send(8'd200, 8'd30, 8'd220, "R2");
        send(8'd90, 8'd150, 8'd40, "R3");
        drain();

        // R6: pass-through forwards channels unchanged
        write_word(12, 1);
        pulse();
        send(8'd0, 8'd255, 8'd7, "R6");
        send(8'd99, 8'd1, 8'd200, "R6");
        write_word(12, 0);
        pulse();
        send(8'd99, 8'd1, 8'd200, "R6");
        drain();

        // R10: random back-pressure with random gaps
        rnd_ready = 1'b1;
        for (int i = 0; i < 150; i++) begin
            send(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), "R10");
            if ($urandom_range(0, 4) == 0) idle();
        end
        idle();
        rnd_ready = 1'b0;
        drain();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", "pixels left in scoreboard", 32'(exp_q.size()), 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule